// File: doc/BRIEF.md
# Memory-Based Interrupt Report Writer

This block turns interrupt events from a set of hardware units into byte writes to a report area in memory, and then raises an interrupt toward the host. Each unit has a 16-bit event vector. Every enabled bit that fires becomes one byte of value 0xFF at the status location for that unit and bit. A source flag byte for the unit follows. After the memory side has accepted every byte of the sequence, a one-cycle host interrupt pulse is raised.

Writes leave the block on a valid/ready request port that carries a byte address and byte data. A 16-bit enable mask sits at a fixed offset of the report area. When a write to that address is seen on the mask update port, the block captures the written value. Events whose bit is disabled in the mask are dropped at capture. Events that arrive while a sequence is being written are OR-merged into the pending state and are reported in a later sequence. In paged mode, each unit's report lands in the 4 KiB page of its engine instance. Units that share an instance number therefore share one page.

Top module: `mbi_report_writer`

## Requirements
- R1: After reset, `wr_valid` and `host_irq` are low and the enable mask is all ones, so every bit of a unit's vector is enabled.
- R2: For each enabled bit b of unit u, exactly one write of data 0xFF goes to address `area_base + page + u*16 + b`. The status writes of a sequence go out in ascending bit order.
- R3: After the last status write of a sequence has been accepted, exactly one source-flag write of 0xFF goes to `area_base + page + 0x400 + u`.
- R4: `host_irq` is high for exactly one cycle. That cycle is the one right after the source-flag write is accepted, and `wr_valid` is low during it.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_addr` keeps its value in the next cycle.
- R6: A mask update whose address equals `area_base + 0x440` loads `mask_wr_data` as the enable mask. Bit b of the mask enables bit b of every unit's vector (1 = enabled). Event bits that are disabled when they arrive produce no write. An event with no enabled bit produces no source write and no `host_irq`.
- R7: A mask update to any other address leaves the enable mask unchanged.
- R8: Event bits that arrive for a unit while its sequence is being written are OR-accumulated. They are reported in one following sequence, and a bit that arrives more than once yields a single byte.
- R9: When several units are pending, each unit gets its own sequence, each ending in its own `host_irq`. The unit with the lowest index is served first.
- R10: `page` is 0 when `page_mode` is low. When `page_mode` is high, `page` is `inst*0x1000`, where `inst` is the unit's field of `unit_inst` (bits `u*3 +: 3`). `area_base` must be 4 KiB aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| area_base | input | 32 | Base address of the report area, 4 KiB aligned |
| page_mode | input | 1 | 1 = each engine instance reports into its own 4 KiB page |
| unit_inst | input | 24 | Engine instance number of each unit, 3 bits per unit |
| evt_in | input | 128 | Event bits, 16 per unit; unit u uses bits u*16 +: 16 |
| mask_wr_valid | input | 1 | Mask update strobe |
| mask_wr_addr | input | 32 | Address of the mask update |
| mask_wr_data | input | 16 | Mask value of the update |
| wr_valid | output | 1 | Byte write request valid |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Memory side accepts the write |
| host_irq | output | 1 | One-cycle host interrupt pulse |

## Verification
The bench aims at events that fire while the write port is stalled. A design that cleared pending bits at the wrong moment would lose a re-fired bit, or it would write that bit's byte twice. Simultaneous events on two units check the service order and that each unit gets its own interrupt; a merged design would show a single pulse. A fully masked event must stay silent; a wrong design would emit a lone source flag or a stray interrupt. A mask update to a neighbouring address must be ignored. Paged mode with different instance numbers exposes a page offset that was dropped or placed at the wrong bit position.

// File: rtl/mbi_pkg.sv
`timescale 1ns/1ps
package mbi_pkg;
   localparam int VEC_W      = 16;
   localparam int VEC_BW     = $clog2(VEC_W);
   localparam int PAGE_SHIFT = 12;
   localparam int SRC_OFS    = 'h400;
   localparam int MASK_OFS   = 'h440;
   localparam int MAX_UNITS  = 64;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_STAT = 2'd1,
      SEQ_SRC  = 2'd2
   } seq_st_e;

   // index of the least significant set bit (0 when none)
   function automatic logic [VEC_BW-1:0] low_bit(input logic [VEC_W-1:0] v);
      logic [VEC_BW-1:0] r;
      r = '0;
      for (int i = VEC_W - 1; i >= 0; i--)
         if (v[i]) r = VEC_BW'(i);
      return r;
   endfunction
endpackage

// File: rtl/mbi_pending.sv
`timescale 1ns/1ps
module mbi_pending import mbi_pkg::*; #(
   parameter int N_UNITS = 8,
   localparam int UW = $clog2(N_UNITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_UNITS*VEC_W-1:0] evt_in,
   input  logic [VEC_W-1:0]         en_mask,
   input  logic                     grab,
   output logic                     any_pend,
   output logic [UW-1:0]            pick_unit,
   output logic [VEC_W-1:0]         pick_vec
);
   logic [VEC_W-1:0] pend [N_UNITS];

   for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
      logic clr;
      assign clr = grab && (pick_unit == UW'(u));
      always_ff @(posedge clk) begin
         if (!rst_n) pend[u] <= '0;
         else        pend[u] <= (clr ? '0 : pend[u]) | (evt_in[u*VEC_W +: VEC_W] & en_mask);
      end
   end

   always_comb begin
      any_pend  = 1'b0;
      pick_unit = '0;
      for (int u = 0; u < N_UNITS; u++) begin
         if (!any_pend && (|pend[u])) begin
            any_pend  = 1'b1;
            pick_unit = UW'(u);
         end
      end
      pick_vec = pend[pick_unit];
   end

   // a unit whose bits are pending and not taken keeps them
   AST_NO_LOST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend[0]) && !(grab && pick_unit == '0) |=> (|pend[0])); // R8
endmodule

// File: rtl/mbi_addr_gen.sv
`timescale 1ns/1ps
module mbi_addr_gen import mbi_pkg::*; #(
   parameter int ADDR_W       = 32,
   parameter int UW           = 3,
   parameter int INST_W       = 3,
   parameter bit PAGE_MODE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] area_base,
   input  logic [INST_W-1:0] inst,
   input  logic [UW-1:0]     unit,
   input  logic [VEC_BW-1:0] bit_idx,
   input  logic              sel_src,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] page_ofs;
   logic [ADDR_W-1:0] area_ofs;

   if (PAGE_MODE_EN) begin : g_paged
      assign page_ofs = ADDR_W'(inst) << PAGE_SHIFT;
   end else begin : g_flat
      logic unused_inst;
      assign unused_inst = ^inst;
      assign page_ofs    = '0;
   end

   always_comb begin
      if (sel_src) area_ofs = ADDR_W'(SRC_OFS) + ADDR_W'(unit);
      else         area_ofs = (ADDR_W'(unit) * ADDR_W'(VEC_W)) + ADDR_W'(bit_idx);
   end

   assign addr = area_base + page_ofs + area_ofs;
endmodule

// File: rtl/mbi_report_writer.sv
`timescale 1ns/1ps
module mbi_report_writer import mbi_pkg::*; #(
   parameter int N_UNITS      = 8,
   parameter int INST_W       = 3,
   parameter int ADDR_W       = 32,
   parameter bit PAGE_MODE_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         area_base,
   input  logic                      page_mode,
   input  logic [N_UNITS*INST_W-1:0] unit_inst,
   input  logic [N_UNITS*VEC_W-1:0]  evt_in,
   input  logic                      mask_wr_valid,
   input  logic [ADDR_W-1:0]         mask_wr_addr,
   input  logic [VEC_W-1:0]          mask_wr_data,
   output logic                      wr_valid,
   output logic [ADDR_W-1:0]         wr_addr,
   output logic [7:0]                wr_data,
   input  logic                      wr_ready,
   output logic                      host_irq
);
   localparam int UW = $clog2(N_UNITS);

   if (N_UNITS < 2 || N_UNITS > MAX_UNITS) begin : g_bad_units
      $error("N_UNITS must lie in 2..64 so the status area fits 1024 bytes");
   end
   if (ADDR_W < PAGE_SHIFT + INST_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the paged layout");
   end

   seq_st_e           state;
   logic [UW-1:0]     unit_q;
   logic [INST_W-1:0] inst_q;
   logic [VEC_W-1:0]  work_q;
   logic [VEC_W-1:0]  mask_q;
   logic              irq_q;

   logic              any_pend, grab, hs;
   logic [UW-1:0]     pick_unit;
   logic [VEC_W-1:0]  pick_vec;
   logic [VEC_W-1:0]  work_rest;

   assign grab      = (state == SEQ_IDLE) && any_pend;
   assign wr_valid  = (state != SEQ_IDLE);
   assign hs        = wr_valid && wr_ready;
   assign work_rest = work_q & (work_q - VEC_W'(1));
   assign wr_data   = 8'hFF;
   assign host_irq  = irq_q;

   mbi_pending #(.N_UNITS(N_UNITS)) u_pend (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .en_mask(mask_q), .grab(grab),
      .any_pend(any_pend), .pick_unit(pick_unit), .pick_vec(pick_vec)
   );

   mbi_addr_gen #(.ADDR_W(ADDR_W), .UW(UW), .INST_W(INST_W), .PAGE_MODE_EN(PAGE_MODE_EN)) u_addr (
      .area_base(area_base), .inst(inst_q), .unit(unit_q), .bit_idx(low_bit(work_q)),
      .sel_src(state == SEQ_SRC), .addr(wr_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         unit_q <= '0;
         inst_q <= '0;
         work_q <= '0;
         mask_q <= '1;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= (state == SEQ_SRC) && hs;
         if (mask_wr_valid && (mask_wr_addr == area_base + ADDR_W'(MASK_OFS)))
            mask_q <= mask_wr_data;
         unique case (state)
            SEQ_IDLE: if (grab) begin
               unit_q <= pick_unit;
               work_q <= pick_vec;
               inst_q <= page_mode ? unit_inst[pick_unit*INST_W +: INST_W] : '0;
               state  <= SEQ_STAT;
            end
            SEQ_STAT: if (hs) begin
               work_q <= work_rest;
               if (work_rest == '0) state <= SEQ_SRC;
            end
            SEQ_SRC: if (hs) state <= SEQ_IDLE;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr)); // R5
   AST_IRQ_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(wr_valid && wr_ready && (wr_addr[PAGE_SHIFT-1:0] >= PAGE_SHIFT'(SRC_OFS)))); // R4
   AST_IRQ_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> !wr_valid && $past(!host_irq)); // R4
   AST_STAT_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && state == SEQ_STAT |-> wr_addr[PAGE_SHIFT-1:0] < PAGE_SHIFT'(SRC_OFS)); // R2
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> area_base[PAGE_SHIFT-1:0] == '0); // R10
endmodule

// File: tb/tb_mbi_report_writer.sv
`timescale 1ns/1ps
module tb_mbi_report_writer;
   localparam int NU = 8;
   localparam int IW = 3;
   localparam logic [31:0] BASE = 32'h0010_0000;

   logic clk = 1'b0;
   logic rst_n;
   logic [31:0] area_base = BASE;
   logic page_mode;
   logic [NU*IW-1:0] unit_inst;
   logic [NU*16-1:0] evt_in;
   logic mask_wr_valid;
   logic [31:0] mask_wr_addr;
   logic [15:0] mask_wr_data;
   logic wr_valid;
   logic [31:0] wr_addr;
   logic [7:0] wr_data;
   logic wr_ready;
   logic host_irq;

   always #2.5 clk = ~clk;

   mbi_report_writer #(.N_UNITS(NU), .INST_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .area_base(area_base), .page_mode(page_mode),
      .unit_inst(unit_inst), .evt_in(evt_in), .mask_wr_valid(mask_wr_valid),
      .mask_wr_addr(mask_wr_addr), .mask_wr_data(mask_wr_data), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .host_irq(host_irq)
   );

   int total = 0;
   int bad = 0;
   int ready_pct = 100;
   int irq_seen = 0;
   int data_bad = 0, hold_bad = 0, irq_long = 0, irq_overlap = 0;
   logic prev_stall = 1'b0, prev_irq = 1'b0;
   logic [31:0] prev_addr = '0;
   logic [32:0] log_q[$];
   logic [32:0] exp_q[$];
   logic [15:0] mask_m;
   logic [IW-1:0] inst_of [NU];
   bit done = 0;

   always @(posedge clk) begin
      #1;
      wr_ready = (int'($urandom % 100) < ready_pct);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && (!wr_valid || wr_addr != prev_addr)) hold_bad++;
         if (wr_valid && wr_ready) begin
            log_q.push_back({1'b0, wr_addr});
            if (wr_data !== 8'hFF) data_bad++;
         end
         if (host_irq) begin
            log_q.push_back({1'b1, 32'h0});
            irq_seen++;
            if (wr_valid) irq_overlap++;
            if (prev_irq) irq_long++;
         end
         prev_stall = wr_valid && !wr_ready;
         prev_addr  = wr_addr;
         prev_irq   = host_irq;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] page_of(input int u);
      return page_mode ? (32'(inst_of[u]) << 12) : 32'h0;
   endfunction

   task automatic add_seq(input int u, input logic [15:0] vec);
      logic [15:0] m;
      m = vec & mask_m;
      if (m == 0) return;
      for (int b = 0; b < 16; b++)
         if (m[b]) exp_q.push_back({1'b0, BASE + page_of(u) + 32'(u*16 + b)});
      exp_q.push_back({1'b0, BASE + page_of(u) + 32'h400 + 32'(u)});
      exp_q.push_back({1'b1, 32'h0});
   endtask

   task automatic pulse(input logic [NU*16-1:0] v);
      @(posedge clk); #1 evt_in = v;
      @(posedge clk); #1 evt_in = '0;
   endtask

   task automatic pulse_unit(input int u, input logic [15:0] vec);
      logic [NU*16-1:0] v;
      v = '0;
      v[u*16 +: 16] = vec;
      pulse(v);
   endtask

   task automatic set_mask(input logic [31:0] a, input logic [15:0] d);
      @(posedge clk); #1 mask_wr_valid = 1'b1; mask_wr_addr = a; mask_wr_data = d;
      @(posedge clk); #1 mask_wr_valid = 1'b0;
      if (a == BASE + 32'h440) mask_m = d;
   endtask

   task automatic wait_irq(input int target);
      for (int i = 0; i < 4000; i++) begin
         if (irq_seen >= target) break;
         @(posedge clk);
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic compare(input string req);
      check({req, " length"}, 64'(log_q.size()), 64'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
         check(req, 64'(log_q[i]), 64'(exp_q[i]));
      log_q.delete();
      exp_q.delete();
   endtask

   task automatic run_one(input string req, input int u, input logic [15:0] vec);
      int t;
      exp_q.delete();
      add_seq(u, vec);
      t = irq_seen + ((exp_q.size() != 0) ? 1 : 0);
      pulse_unit(u, vec);
      if (exp_q.size() != 0) wait_irq(t);
      else repeat (40) @(posedge clk);
      compare(req);
   endtask

   task automatic pack_inst();
      for (int u = 0; u < NU; u++) unit_inst[u*IW +: IW] = inst_of[u];
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; page_mode = 1'b0; evt_in = '0; mask_wr_valid = 1'b0;
      mask_wr_addr = '0; mask_wr_data = '0; mask_m = 16'hFFFF;
      for (int u = 0; u < NU; u++) inst_of[u] = IW'(u);
      pack_inst();
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
      check("R1 host_irq after reset", 64'(host_irq), 64'd0);

      // R1 mask all ones, R2/R3 full vector
      run_one("R1 R2 R3 full vector", 0, 16'hFFFF);
      ready_pct = 50;
      run_one("R2 sparse bits", 7, 16'h8421);

      // R6 mask load
      set_mask(BASE + 32'h440, 16'h00FF);
      run_one("R6 partial mask", 3, 16'hF0F0);
      // R7 neighbouring address ignored
      set_mask(BASE + 32'h441, 16'h0000);
      run_one("R7 mask unchanged", 4, 16'h0110);
      set_mask(BASE + 32'h440, 16'h0000);
      run_one("R6 all disabled", 5, 16'hFFFF);
      set_mask(BASE + 32'h440, 16'hFFFF);

      // R8 accumulation during a stalled sequence
      begin
         int t;
         ready_pct = 0;
         exp_q.delete();
         add_seq(2, 16'h0003);
         add_seq(2, 16'h0021);
         t = irq_seen + 2;
         pulse_unit(2, 16'h0003);
         repeat (4) @(posedge clk);
         pulse_unit(2, 16'h0001);
         pulse_unit(2, 16'h0020);
         pulse_unit(2, 16'h0020);
         ready_pct = 60;
         wait_irq(t);
         compare("R8 accumulate");
      end

      // R9 two units together, lowest first
      begin
         logic [NU*16-1:0] v;
         int t;
         v = '0;
         v[5*16 +: 16] = 16'h0002;
         v[1*16 +: 16] = 16'h4000;
         exp_q.delete();
         add_seq(1, 16'h4000);
         add_seq(5, 16'h0002);
         t = irq_seen + 2;
         pulse(v);
         wait_irq(t);
         compare("R9 order");
      end

      // R10 paged layout
      page_mode = 1'b1;
      inst_of[3] = 3'd2; inst_of[6] = 3'd7; pack_inst();
      run_one("R10 page inst2", 3, 16'h0081);
      run_one("R10 page inst7", 6, 16'h1000);
      page_mode = 1'b0;
      run_one("R10 flat mode", 6, 16'h1000);

      // constrained random
      for (int it = 0; it < 40; it++) begin
         int u;
         logic [15:0] vec;
         u = int'($urandom % NU);
         vec = 16'($urandom);
         if (it % 6 == 0) vec = 16'h0000;
         if ($urandom % 3 == 0) set_mask(BASE + 32'h440, 16'($urandom));
         else if ($urandom % 4 == 0) set_mask(BASE + 32'h440, 16'hFFFF);
         page_mode = 1'($urandom);
         for (int k = 0; k < NU; k++) inst_of[k] = IW'($urandom);
         pack_inst();
         ready_pct = 30 + int'($urandom % 71);
         run_one("R2 R3 R6 R10 random", u, vec);
      end

      check("R5 hold under stall", 64'(hold_bad), 64'd0);
      check("R4 pulse single cycle", 64'(irq_long), 64'd0);
      check("R4 no write during irq", 64'(irq_overlap), 64'd0);
      check("R2 data byte 0xFF", 64'(data_bad), 64'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule